// File: doc/BRIEF.md
# Type-0 Configuration Header Register File

This block holds the 64-byte configuration header of a single bus function. A configuration agent sends it requests, each carrying a byte offset, an access size of 1, 2 or 4 bytes, a read/write flag and write data. One cycle later the block answers with little-endian read data or an error flag. Every fixed header field takes its value from a parameter. These fields are the identification words, the class bytes, the header type, the interrupt pin and the timing bytes. The writable fields reset to parameter values too.

Six base address slots sit at consecutive 32-bit offsets starting at 0x10. Each slot has a size parameter that is a power of two. A size of zero marks the slot as absent. Software can size a slot by writing all ones to it. When software writes a real address, the block records the decoded base for that slot and raises a one-cycle mapping event. An address-routing unit outside the block can follow these events to keep its windows up to date.

Top module: `pcfg_hdr`

## Requirements
- R1: After synchronous reset, every header field reads its parameter value, every recorded base reads zero, every mapped flag is low and no response or event is pending.
- R2: A request is answered exactly one cycle after its valid strobe. A read of size 1, 2 or 4 returns the bytes from the offset upward in little-endian order, with unused upper bytes zero. Bytes past offset 0x3F read as zero. A write response carries zero data. With no request, the response valid output stays low.
- R3: A request at offset 0x40 or above, or with a size other than 1, 2 or 4, raises the error flag with zero data and changes no state.
- R4: Single-byte writes change only three bytes: cache line size (0x0C), latency timer (0x0D) and interrupt line (0x3C). A byte write anywhere else is ignored.
- R5: Two-byte writes change only three places: the command word (0x04), the status word (0x06), and the cache line size and latency timer pair at 0x0C, with the low byte going to cache line size. A two-byte write anywhere else is ignored.
- R6: A four-byte write at 0x04 loads bits 15:0 into the command word and leaves the status word unchanged. A four-byte write to any location other than 0x04, a slot or the ROM word (0x30) is ignored.
- R7: A slot whose reset value has bit 0 set is an I/O slot, and its low 2 bits are read-only. Any other slot is a memory slot, and its low 4 bits are read-only. Writing 0xFFFFFFFF to an implemented slot stores ~(size-1) combined with its read-only bits.
- R8: Any other four-byte write to an implemented slot stores the written value with the read-only low bits replaced by their stored values.
- R9: On a non-probe slot write, the address part is the written value with bit 0 cleared (I/O) or bits 1:0 cleared (memory). If the address part is nonzero, it becomes the recorded base and the mapped flag is set. If the address part is zero, nothing is recorded.
- R10: A slot whose size parameter is zero always reads zero. It ignores writes and never raises an event.
- R11: Writing 0xFFFFFFFE to the ROM word (0x30) stores 0xFFFFFFFF. Any other four-byte value is stored as written.
- R12: A base recording raises exactly one event, in the same cycle as the write's response. The event is an add if the slot was unmapped and an update otherwise. It carries the slot index, the previous base and the new base.
- R13: The effect of a write is visible to a read issued on the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 8 | Byte offset into configuration space |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Request was out of range or of illegal size |
| rsp_rdata | output | 32 | Little-endian read data |
| map_add | output | 1 | First base recorded for a slot |
| map_update | output | 1 | Base of an already mapped slot changed |
| map_bar_idx | output | 3 | Slot index of the event |
| map_old_base | output | 32 | Previously recorded base (for an update) |
| map_new_base | output | 32 | Newly recorded base |
| bar_base | output | 192 | Recorded base per slot, slot n at bits 32n+31:32n |
| bar_mapped | output | 6 | Mapped flag per slot |

## Verification
The bench builds the block with every slot kind it supports. Slot 0 is a 4 KiB memory slot with nonzero type bits. Slot 1 is a 256-byte I/O slot. Slot 3 is a memory slot of the 16-byte minimum with nonzero type bits. Slot 4 is an I/O slot of the 4-byte minimum. Slots 2 and 5 are absent. With this mix, probing can be checked at both minimum sizes, and the read-only type bits can be checked for both slot kinds. It also covers absent slots, both address-part masks, and a zero address part. All identification fields are distinct and nonzero, so a misplaced byte in the header image shows up in the readback of every word.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

    localparam int HDR_BYTES   = 64;
    localparam int BAR_COUNT   = 6;
    localparam int OFF_W       = 8;
    localparam int DW          = 32;
    localparam int BAR_IDX_W   = $clog2(BAR_COUNT);
    localparam int BAR_FIRST_I = 16;

    localparam logic [OFF_W-1:0] BAR_FIRST   = OFF_W'(BAR_FIRST_I);
    localparam logic [OFF_W-1:0] BAR_END     = OFF_W'(BAR_FIRST_I + 4 * BAR_COUNT);
    localparam logic [OFF_W-1:0] OFF_CMD     = 8'h04;
    localparam logic [OFF_W-1:0] OFF_STAT    = 8'h06;
    localparam logic [OFF_W-1:0] OFF_CACHE   = 8'h0C;
    localparam logic [OFF_W-1:0] OFF_LAT     = 8'h0D;
    localparam logic [OFF_W-1:0] OFF_ROM     = 8'h30;
    localparam logic [OFF_W-1:0] OFF_INTLINE = 8'h3C;

    // writable header fields plus the registered response
    typedef struct packed {
        logic [15:0]   cmd;
        logic [15:0]   stat;
        logic [7:0]    cache;
        logic [7:0]    lat;
        logic [7:0]    intline;
        logic [DW-1:0] rom;
        logic          rsp_valid;
        logic          rsp_err;
        logic [DW-1:0] rsp_data;
    } hdr_state_t;

    // one base address slot with its tracking and event registers
    typedef struct packed {
        logic [DW-1:0] bar;
        logic [DW-1:0] base;
        logic          mapped;
        logic          add;
        logic          upd;
        logic [DW-1:0] old_base;
        logic [DW-1:0] new_base;
    } bar_state_t;

endpackage

// File: rtl/pcfg_rdmux.sv
module pcfg_rdmux
    import pcfg_pkg::*;
(
    input  logic [HDR_BYTES*8-1:0] image,
    input  logic [OFF_W-1:0]       offset,
    input  logic [2:0]             size,
    output logic [DW-1:0]          data
);

    // constant indices only: every header byte is compared against each lane
    always_comb begin
        data = '0;
        for (int k = 0; k < DW / 8; k++) begin
            for (int b = 0; b < HDR_BYTES; b++) begin
                if (k < int'(size) && (int'(offset) + k) == b) begin
                    data[k*8 +: 8] = image[b*8 +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/pcfg_bar.sv
module pcfg_bar
    import pcfg_pkg::*;
#(
    parameter logic [DW-1:0] INIT = '0,
    parameter logic [DW-1:0] SIZE = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] bar_val,
    output logic [DW-1:0] base,
    output logic          mapped,
    output logic          ev_add,
    output logic          ev_upd,
    output logic [DW-1:0] ev_old,
    output logic [DW-1:0] ev_new
);

    localparam bit            IMPL      = (SIZE != '0);
    localparam bit            IS_IO     = INIT[0];
    localparam logic [DW-1:0] TYPE_MASK = IS_IO ? DW'(32'h3) : DW'(32'hF);
    localparam logic [DW-1:0] ADDR_MASK = IS_IO ? ~DW'(32'h1) : ~DW'(32'h3);
    localparam logic [DW-1:0] SIZE_MASK = ~(SIZE - DW'(1));
    localparam logic [DW-1:0] RST_BAR   = IMPL ? INIT : '0;

    bar_state_t q, d;
    logic          wr_go;
    logic [DW-1:0] addr_part;

    assign wr_go     = wr_en && IMPL;
    assign addr_part = wdata & ADDR_MASK;

    always_comb begin
        d     = q;
        d.add = 1'b0;
        d.upd = 1'b0;
        if (wr_go) begin
            if (wdata == '1) begin
                d.bar = SIZE_MASK | (q.bar & TYPE_MASK);
            end else begin
                d.bar = (wdata & ~TYPE_MASK) | (q.bar & TYPE_MASK);
                if (addr_part != '0) begin
                    d.add      = !q.mapped;
                    d.upd      = q.mapped;
                    d.old_base = q.base;
                    d.new_base = addr_part;
                    d.base     = addr_part;
                    d.mapped   = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{bar: RST_BAR, base: '0, mapped: 1'b0, add: 1'b0, upd: 1'b0,
                   old_base: '0, new_base: '0};
        end else begin
            q <= d;
        end
    end

    assign bar_val = q.bar;
    assign base    = q.base;
    assign mapped  = q.mapped;
    assign ev_add  = q.add;
    assign ev_upd  = q.upd;
    assign ev_old  = q.old_base;
    assign ev_new  = q.new_base;

    // R7: type bits never move once out of reset
    p_type_bits_r7: assert property (@(posedge clk) disable iff (rst)
        $stable(q.bar & TYPE_MASK));

    // R9: a mapped slot always holds a nonzero base
    p_base_valid_r9: assert property (@(posedge clk) disable iff (rst)
        q.mapped |-> (q.base != '0));

    // R12: add only for a slot that was unmapped before the write
    p_add_first_r12: assert property (@(posedge clk) disable iff (rst)
        q.add |-> !$past(q.mapped));

    // R12: update reports the base held before the write
    p_upd_old_r12: assert property (@(posedge clk) disable iff (rst)
        q.upd |-> (q.old_base == $past(q.base)));

endmodule

// File: rtl/pcfg_hdr.sv
module pcfg_hdr
    import pcfg_pkg::*;
#(
    parameter logic [15:0]             VENDOR_ID   = 16'hABCD,
    parameter logic [15:0]             DEVICE_ID   = 16'h0102,
    parameter logic [15:0]             CMD_INIT    = 16'h0000,
    parameter logic [15:0]             STATUS_INIT = 16'h0290,
    parameter logic [7:0]              REVISION    = 8'h01,
    parameter logic [7:0]              PROG_IF     = 8'h00,
    parameter logic [7:0]              SUBCLASS    = 8'h00,
    parameter logic [7:0]              CLASS_CODE  = 8'h02,
    parameter logic [7:0]              CACHE_INIT  = 8'h00,
    parameter logic [7:0]              LAT_INIT    = 8'h00,
    parameter logic [7:0]              HEADER_TYPE = 8'h00,
    parameter logic [7:0]              BIST_INIT   = 8'h00,
    parameter logic [BAR_COUNT*DW-1:0] BAR_INIT    = '0,
    parameter logic [BAR_COUNT*DW-1:0] BAR_SIZE    = {{(BAR_COUNT-1){32'h0}}, 32'h1000},
    parameter logic [DW-1:0]           CIS_PTR     = '0,
    parameter logic [15:0]             SUBSYS_VID  = 16'h0000,
    parameter logic [15:0]             SUBSYS_ID   = 16'h0000,
    parameter logic [DW-1:0]           ROM_INIT    = '0,
    parameter logic [7:0]              INT_LINE    = 8'h00,
    parameter logic [7:0]              INT_PIN     = 8'h01,
    parameter logic [7:0]              MIN_GNT     = 8'h00,
    parameter logic [7:0]              MAX_LAT     = 8'h00
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [OFF_W-1:0]        req_offset,
    input  logic [2:0]              req_size,
    input  logic [DW-1:0]           req_wdata,
    output logic                    rsp_valid,
    output logic                    rsp_err,
    output logic [DW-1:0]           rsp_rdata,
    output logic                    map_add,
    output logic                    map_update,
    output logic [BAR_IDX_W-1:0]    map_bar_idx,
    output logic [DW-1:0]           map_old_base,
    output logic [DW-1:0]           map_new_base,
    output logic [BAR_COUNT*DW-1:0] bar_base,
    output logic [BAR_COUNT-1:0]    bar_mapped
);

    localparam hdr_state_t RST_STATE = '{
        cmd: CMD_INIT, stat: STATUS_INIT, cache: CACHE_INIT, lat: LAT_INIT,
        intline: INT_LINE, rom: ROM_INIT, rsp_valid: 1'b0, rsp_err: 1'b0,
        rsp_data: '0};

    hdr_state_t q, d;

    logic                   size_ok, acc_ok, do_wr, bar_hit;
    logic [BAR_IDX_W-1:0]   bar_sel;
    logic [BAR_COUNT-1:0]   bar_wr, ev_add, ev_upd;
    logic [DW-1:0]          bar_val [BAR_COUNT];
    logic [DW-1:0]          ev_old  [BAR_COUNT];
    logic [DW-1:0]          ev_new  [BAR_COUNT];
    logic [HDR_BYTES*8-1:0] image;
    logic [DW-1:0]          rd_word;

    // ---------------- request decode ----------------
    assign size_ok = (req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4);
    assign acc_ok  = req_valid && size_ok && (req_offset < OFF_W'(HDR_BYTES));
    assign do_wr   = acc_ok && req_write;
    assign bar_hit = do_wr && (req_size == 3'd4) && (req_offset >= BAR_FIRST)
                     && (req_offset < BAR_END) && (req_offset[1:0] == 2'b00);
    assign bar_sel = BAR_IDX_W'((req_offset - BAR_FIRST) >> 2);

    always_comb begin
        for (int i = 0; i < BAR_COUNT; i++) begin
            bar_wr[i] = bar_hit && (bar_sel == BAR_IDX_W'(i));
        end
    end

    // ---------------- base address slots ----------------
    for (genvar g = 0; g < BAR_COUNT; g++) begin : g_bar
        pcfg_bar #(
            .INIT (BAR_INIT[g*DW +: DW]),
            .SIZE (BAR_SIZE[g*DW +: DW])
        ) u_bar (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (bar_wr[g]),
            .wdata   (req_wdata),
            .bar_val (bar_val[g]),
            .base    (bar_base[g*DW +: DW]),
            .mapped  (bar_mapped[g]),
            .ev_add  (ev_add[g]),
            .ev_upd  (ev_upd[g]),
            .ev_old  (ev_old[g]),
            .ev_new  (ev_new[g])
        );
    end

    // ---------------- header image ----------------
    always_comb begin
        image = '0;
        image[8'h00*8 +: 16] = VENDOR_ID;
        image[8'h02*8 +: 16] = DEVICE_ID;
        image[8'h04*8 +: 16] = q.cmd;
        image[8'h06*8 +: 16] = q.stat;
        image[8'h08*8 +: 8]  = REVISION;
        image[8'h09*8 +: 8]  = PROG_IF;
        image[8'h0A*8 +: 8]  = SUBCLASS;
        image[8'h0B*8 +: 8]  = CLASS_CODE;
        image[8'h0C*8 +: 8]  = q.cache;
        image[8'h0D*8 +: 8]  = q.lat;
        image[8'h0E*8 +: 8]  = HEADER_TYPE;
        image[8'h0F*8 +: 8]  = BIST_INIT;
        for (int i = 0; i < BAR_COUNT; i++) begin
            image[(BAR_FIRST_I + 4*i)*8 +: DW] = bar_val[i];
        end
        image[8'h28*8 +: 32] = CIS_PTR;
        image[8'h2C*8 +: 16] = SUBSYS_VID;
        image[8'h2E*8 +: 16] = SUBSYS_ID;
        image[8'h30*8 +: 32] = q.rom;
        image[8'h3C*8 +: 8]  = q.intline;
        image[8'h3D*8 +: 8]  = INT_PIN;
        image[8'h3E*8 +: 8]  = MIN_GNT;
        image[8'h3F*8 +: 8]  = MAX_LAT;
    end

    pcfg_rdmux u_rdmux (
        .image  (image),
        .offset (req_offset),
        .size   (req_size),
        .data   (rd_word)
    );

    // ---------------- next state ----------------
    always_comb begin
        d           = q;
        d.rsp_valid = req_valid;
        d.rsp_err   = req_valid && !acc_ok;
        d.rsp_data  = (acc_ok && !req_write) ? rd_word : '0;
        if (do_wr) begin
            case (req_size)
                3'd1: begin
                    case (req_offset)
                        OFF_CACHE:   d.cache   = req_wdata[7:0];
                        OFF_LAT:     d.lat     = req_wdata[7:0];
                        OFF_INTLINE: d.intline = req_wdata[7:0];
                        default: ;
                    endcase
                end
                3'd2: begin
                    case (req_offset)
                        OFF_CMD:  d.cmd  = req_wdata[15:0];
                        OFF_STAT: d.stat = req_wdata[15:0];
                        OFF_CACHE: begin
                            d.cache = req_wdata[7:0];
                            d.lat   = req_wdata[15:8];
                        end
                        default: ;
                    endcase
                end
                3'd4: begin
                    case (req_offset)
                        OFF_CMD: d.cmd = req_wdata[15:0];
                        OFF_ROM: d.rom = (req_wdata == 32'hFFFF_FFFE) ? '1 : req_wdata;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST_STATE;
        end else begin
            q <= d;
        end
    end

    // ---------------- outputs ----------------
    assign rsp_valid = q.rsp_valid;
    assign rsp_err   = q.rsp_err;
    assign rsp_rdata = q.rsp_data;

    always_comb begin
        map_bar_idx  = '0;
        map_old_base = '0;
        map_new_base = '0;
        for (int i = 0; i < BAR_COUNT; i++) begin
            if (ev_add[i] || ev_upd[i]) begin
                map_bar_idx  = BAR_IDX_W'(i);
                map_old_base = ev_old[i];
                map_new_base = ev_new[i];
            end
        end
    end
    assign map_add    = |ev_add;
    assign map_update = |ev_upd;

    // R2: every request is answered on the next cycle
    p_rsp_next_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R3: out-of-range requests flag an error and leave state alone
    p_err_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_offset >= OFF_W'(HDR_BYTES)) |=>
        (rsp_err && $stable(q.cmd) && $stable(q.rom) && $stable(bar_mapped)));

    // R12: at most one event from all slots together
    p_one_event_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_add, ev_upd}));

    // R12: events only travel with a good response
    p_event_rsp_r12: assert property (@(posedge clk) disable iff (rst)
        (map_add || map_update) |-> (rsp_valid && !rsp_err));

endmodule

// File: tb/pcfg_hdr_tb.sv
module pcfg_hdr_tb;
    import pcfg_pkg::*;

    localparam int CLK_PERIOD = 10;

    localparam logic [15:0] T_VID   = 16'hC0DE;
    localparam logic [15:0] T_DID   = 16'h4A21;
    localparam logic [15:0] T_CMD   = 16'h0006;
    localparam logic [15:0] T_STAT  = 16'h0230;
    localparam logic [7:0]  T_REV   = 8'h05;
    localparam logic [7:0]  T_PIF   = 8'h01;
    localparam logic [7:0]  T_SUB   = 8'h80;
    localparam logic [7:0]  T_CLS   = 8'h0B;
    localparam logic [7:0]  T_CACHE = 8'h08;
    localparam logic [7:0]  T_LAT   = 8'h20;
    localparam logic [7:0]  T_HDR   = 8'h80;
    localparam logic [7:0]  T_BIST  = 8'h40;
    localparam logic [BAR_COUNT*32-1:0] T_BAR_INIT =
        {32'h0, 32'h1, 32'h4, 32'h0, 32'h1, 32'h8};
    localparam logic [BAR_COUNT*32-1:0] T_BAR_SIZE =
        {32'h0, 32'h4, 32'h10, 32'h0, 32'h100, 32'h1000};
    localparam logic [31:0] T_CIS   = 32'h0000_0140;
    localparam logic [15:0] T_SVID  = 16'h1357;
    localparam logic [15:0] T_SID   = 16'h2468;
    localparam logic [31:0] T_ROM   = 32'h0000_0000;
    localparam logic [7:0]  T_ILINE = 8'h0A;
    localparam logic [7:0]  T_IPIN  = 8'h01;
    localparam logic [7:0]  T_MGNT  = 8'h03;
    localparam logic [7:0]  T_MLAT  = 8'h09;

    logic                    clk = 1'b0;
    logic                    rst;
    logic                    req_valid, req_write;
    logic [7:0]              req_offset;
    logic [2:0]              req_size;
    logic [31:0]             req_wdata;
    logic                    rsp_valid, rsp_err;
    logic [31:0]             rsp_rdata;
    logic                    map_add, map_update;
    logic [BAR_IDX_W-1:0]    map_bar_idx;
    logic [31:0]             map_old_base, map_new_base;
    logic [BAR_COUNT*32-1:0] bar_base;
    logic [BAR_COUNT-1:0]    bar_mapped;

    pcfg_hdr #(
        .VENDOR_ID(T_VID), .DEVICE_ID(T_DID), .CMD_INIT(T_CMD), .STATUS_INIT(T_STAT),
        .REVISION(T_REV), .PROG_IF(T_PIF), .SUBCLASS(T_SUB), .CLASS_CODE(T_CLS),
        .CACHE_INIT(T_CACHE), .LAT_INIT(T_LAT), .HEADER_TYPE(T_HDR), .BIST_INIT(T_BIST),
        .BAR_INIT(T_BAR_INIT), .BAR_SIZE(T_BAR_SIZE), .CIS_PTR(T_CIS),
        .SUBSYS_VID(T_SVID), .SUBSYS_ID(T_SID), .ROM_INIT(T_ROM), .INT_LINE(T_ILINE),
        .INT_PIN(T_IPIN), .MIN_GNT(T_MGNT), .MAX_LAT(T_MLAT)
    ) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .map_add(map_add), .map_update(map_update), .map_bar_idx(map_bar_idx),
        .map_old_base(map_old_base), .map_new_base(map_new_base),
        .bar_base(bar_base), .bar_mapped(bar_mapped)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference ----------------
    logic [7:0]  mdl    [64];
    logic [31:0] m_base [BAR_COUNT];
    logic        m_map  [BAR_COUNT];
    int checks = 0;
    int fails  = 0;

    function automatic void put(int off, int nb, logic [31:0] v);
        for (int k = 0; k < nb; k++) mdl[off+k] = v[k*8 +: 8];
    endfunction

    function automatic logic [31:0] get32(int off);
        return {mdl[off+3], mdl[off+2], mdl[off+1], mdl[off]};
    endfunction

    function automatic void mdl_reset();
        for (int b = 0; b < 64; b++) mdl[b] = 8'h00;
        put(0, 2, T_VID);   put(2, 2, T_DID);   put(4, 2, T_CMD);  put(6, 2, T_STAT);
        put(8, 1, T_REV);   put(9, 1, T_PIF);   put(10, 1, T_SUB); put(11, 1, T_CLS);
        put(12, 1, T_CACHE); put(13, 1, T_LAT); put(14, 1, T_HDR); put(15, 1, T_BIST);
        for (int i = 0; i < BAR_COUNT; i++)
            put(16 + 4*i, 4, (T_BAR_SIZE[i*32 +: 32] != 0) ? T_BAR_INIT[i*32 +: 32] : 32'h0);
        put(40, 4, T_CIS);  put(44, 2, T_SVID); put(46, 2, T_SID); put(48, 4, T_ROM);
        put(60, 1, T_ILINE); put(61, 1, T_IPIN); put(62, 1, T_MGNT); put(63, 1, T_MLAT);
        for (int i = 0; i < BAR_COUNT; i++) begin
            m_base[i] = 32'h0;
            m_map[i]  = 1'b0;
        end
    endfunction

    task automatic mdl_write(int off, int sz, logic [31:0] w,
                             output logic ea, output logic eu,
                             output logic [31:0] ei, output logic [31:0] eo,
                             output logic [31:0] en);
        int          i;
        logic [31:0] bsz, cur, lm, addr;
        ea = 0; eu = 0; ei = 0; eo = 0; en = 0;
        if (sz == 1 && (off == 12 || off == 13 || off == 60)) put(off, 1, w);
        else if (sz == 2 && (off == 4 || off == 6 || off == 12)) put(off, 2, w);
        else if (sz == 4 && off == 4) put(4, 2, w);
        else if (sz == 4 && off == 48) put(48, 4, (w == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : w);
        else if (sz == 4 && off >= 16 && off < 40 && (off % 4) == 0) begin
            i   = (off - 16) / 4;
            bsz = T_BAR_SIZE[i*32 +: 32];
            cur = get32(off);
            lm  = cur[0] ? 32'h3 : 32'hF;
            if (bsz != 0) begin
                if (w == 32'hFFFF_FFFF) begin
                    put(off, 4, ~(bsz - 1) | (cur & lm));
                end else begin
                    put(off, 4, (w & ~lm) | (cur & lm));
                    addr = cur[0] ? (w & ~32'h1) : (w & ~32'h3);
                    if (addr != 0) begin
                        ea = !m_map[i]; eu = m_map[i]; ei = i;
                        eo = m_base[i]; en = addr;
                        m_base[i] = addr; m_map[i] = 1'b1;
                    end
                end
            end
        end
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cmp_bases(string tag);
        for (int i = 0; i < BAR_COUNT; i++) begin
            chk(tag, "bar_base", bar_base[i*32 +: 32], m_base[i]);
            chk(tag, "bar_mapped", 32'(bar_mapped[i]), 32'(m_map[i]));
        end
    endtask

    // called and returns at a falling edge
    task automatic do_req(string tag, bit wr, int off, int sz, logic [31:0] wd);
        logic        err, e_add, e_upd;
        logic [31:0] e_rd, e_idx, e_old, e_new;
        err  = (off >= 64) || !(sz == 1 || sz == 2 || sz == 4);
        e_rd = 0; e_add = 0; e_upd = 0; e_idx = 0; e_old = 0; e_new = 0;
        if (!err && !wr)
            for (int k = 0; k < sz; k++)
                if (off + k < 64) e_rd[k*8 +: 8] = mdl[off+k];
        if (!err && wr) mdl_write(off, sz, wd, e_add, e_upd, e_idx, e_old, e_new);
        req_valid = 1'b1; req_write = wr; req_offset = 8'(off);
        req_size = 3'(sz); req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk(tag, "rsp_valid", 32'(rsp_valid), 32'd1);
        chk(tag, "rsp_err", 32'(rsp_err), 32'(err));
        chk(tag, "rsp_rdata", rsp_rdata, e_rd);
        chk("R12", "map_add", 32'(map_add), 32'(e_add));
        chk("R12", "map_update", 32'(map_update), 32'(e_upd));
        if (e_add || e_upd) begin
            chk("R12", "map_bar_idx", 32'(map_bar_idx), e_idx);
            chk("R12", "map_old_base", map_old_base, e_old);
            chk("R12", "map_new_base", map_new_base, e_new);
        end
        cmp_bases("R9");
    endtask

    task automatic idle();
        @(negedge clk);
        chk("R2", "idle rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R12", "idle event", 32'(map_add | map_update), 32'd0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mdl_reset();
        chk("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1", "events", 32'(map_add | map_update), 32'd0);
        cmp_bases("R1");
        for (int a = 0; a < 64; a += 4) do_req("R1", 0, a, 4, 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        rst = 1'b1; req_valid = 0; req_write = 0; req_offset = 0; req_size = 0; req_wdata = 0;
        @(negedge clk);
        do_reset();

        // R2: sizes, little-endian, tail past the header
        do_req("R2", 0, 9, 1, 0);
        do_req("R2", 0, 14, 1, 0);
        do_req("R2", 0, 2, 2, 0);
        do_req("R2", 0, 46, 2, 0);
        do_req("R2", 0, 62, 4, 0);
        do_req("R2", 0, 1, 4, 0);
        idle();

        // R3: out of range and bad sizes
        do_req("R3", 0, 8'h40, 4, 0);
        do_req("R3", 1, 8'h44, 4, 32'h1234_5678);
        do_req("R3", 1, 8'h40, 2, 32'hFFFF);
        do_req("R3", 0, 0, 3, 0);
        do_req("R3", 1, 12, 3, 32'h77);
        do_req("R3", 0, 12, 4, 0);

        // R4: byte writes
        do_req("R4", 1, 12, 1, 32'h10);
        do_req("R4", 1, 13, 1, 32'hF8);
        do_req("R4", 1, 60, 1, 32'h5B);
        do_req("R4", 1, 0, 1, 32'hEE);
        do_req("R4", 1, 61, 1, 32'hEE);
        do_req("R4", 1, 4, 1, 32'hEE);
        do_req("R4", 0, 0, 4, 0);
        do_req("R4", 0, 12, 4, 0);
        do_req("R4", 0, 60, 4, 0);

        // R5: halfword writes
        do_req("R5", 1, 4, 2, 32'h0147);
        do_req("R5", 1, 6, 2, 32'h0AA0);
        do_req("R5", 1, 12, 2, 32'h3C40);
        do_req("R5", 1, 0, 2, 32'h1111);
        do_req("R5", 1, 8, 2, 32'h2222);
        do_req("R5", 0, 4, 4, 0);
        do_req("R5", 0, 12, 4, 0);
        do_req("R5", 0, 8, 4, 0);

        // R6: word writes to non-slot locations
        do_req("R6", 1, 4, 4, 32'hDEAD_0103);
        do_req("R6", 0, 4, 4, 0);
        do_req("R6", 1, 0, 4, 32'h5555_AAAA);
        do_req("R6", 1, 40, 4, 32'h5555_AAAA);
        do_req("R6", 1, 18, 4, 32'h8000_0000);
        do_req("R6", 0, 0, 4, 0);
        do_req("R6", 0, 40, 4, 0);
        do_req("R6", 0, 16, 4, 0);

        // R7: probe every slot
        for (int i = 0; i < BAR_COUNT; i++) begin
            do_req("R7", 1, 16 + 4*i, 4, 32'hFFFF_FFFF);
            do_req("R7", 0, 16 + 4*i, 4, 0);
        end

        // R8 / R9 / R12: address writes and base tracking
        do_req("R8", 1, 16, 4, 32'h8000_0000);
        do_req("R8", 0, 16, 4, 0);
        do_req("R9", 1, 16, 4, 32'h9000_0005);
        do_req("R8", 0, 16, 4, 0);
        do_req("R9", 1, 20, 4, 32'h0000_C001);
        do_req("R8", 0, 20, 4, 0);
        do_req("R9", 1, 20, 4, 32'h0000_0002);
        do_req("R9", 1, 28, 4, 32'h0000_0003);
        do_req("R8", 0, 28, 4, 0);
        do_req("R9", 1, 28, 4, 32'h0000_0000);
        do_req("R9", 1, 32, 4, 32'h0000_0003);
        do_req("R8", 0, 32, 4, 0);
        do_req("R9", 1, 16, 4, 32'hFFFF_FFFF);
        do_req("R8", 0, 16, 4, 0);
        idle();

        // R10: absent slots
        do_req("R10", 1, 24, 4, 32'h1234_5678);
        do_req("R10", 0, 24, 4, 0);
        do_req("R10", 1, 36, 4, 32'hFFFF_FFFF);
        do_req("R10", 0, 36, 4, 0);

        // R11: ROM word
        do_req("R11", 1, 48, 4, 32'hFFFF_FFFE);
        do_req("R11", 0, 48, 4, 0);
        do_req("R11", 1, 48, 4, 32'h1234_5678);
        do_req("R11", 0, 48, 4, 0);
        do_req("R11", 1, 48, 4, 32'hFFFF_FFFF);
        do_req("R11", 0, 48, 4, 0);
        do_req("R11", 1, 48, 2, 32'h0000_AAAA);
        do_req("R11", 0, 48, 4, 0);

        // R13: write then read on the very next cycle
        do_req("R13", 1, 13, 1, 32'h99);
        do_req("R13", 0, 13, 1, 0);
        do_req("R13", 1, 16, 4, 32'hA000_0000);
        do_req("R13", 0, 16, 4, 0);

        // R1: reset in mid-run restores everything
        do_reset();
        do_req("R1", 1, 16, 4, 32'h4000_0000);
        idle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule